// File: doc/BRIEF.md
# Single-Wire Reset and Command Responder

This block is the target-side front end of a single-wire, open-drain serial memory link. It watches the shared data line through a two-flop synchronizer. While the line is low, it counts microsecond tick enables. A long low period is taken as a bus reset. The block answers it with a presence pulse, then takes command bytes from host-started write slots. Bits arrive least significant first.

The first byte after presence must be the skip-addressing code. The next byte may then be the profile-programming code. In that case the block raises a one-cycle command strobe and returns a fixed acknowledge byte over the next eight host-started read slots. Any other byte in either position sends the block back to waiting for a bus reset. The block has no memory array and no programming-voltage control.

The controller has six states:
- `ST_WAIT_RST`: idle, all slots are ignored.
- `ST_PP_WAIT`: waiting before the presence pulse.
- `ST_PP_DRIVE`: driving the presence pulse.
- `ST_RX_SKIP`: receiving the first byte.
- `ST_RX_CMD`: receiving the command byte.
- `ST_TX_ACK`: answering read slots.

Its transitions are:
- Bus reset: a guaranteed reset followed by line release, from any state, goes to `ST_PP_WAIT`.
- Wait done: `ST_PP_WAIT` goes to `ST_PP_DRIVE`.
- Presence done: `ST_PP_DRIVE` goes to `ST_RX_SKIP`.
- Skip match: `ST_RX_SKIP` goes to `ST_RX_CMD`.
- Program match: `ST_RX_CMD` goes to `ST_TX_ACK`.
- Mismatch: a wrong byte in `ST_RX_SKIP` or `ST_RX_CMD` goes to `ST_WAIT_RST`.
- Abandon: a low period past the lower threshold in `ST_RX_SKIP`, `ST_RX_CMD` or `ST_TX_ACK` goes to `ST_WAIT_RST`.
- Ack done: the last acknowledge bit in `ST_TX_ACK` goes to `ST_WAIT_RST`.

Top module: `sw_responder`

## Requirements
- R1: After `rst_n` the block does not pull the line and does not strobe. Until the first guaranteed bus reset, it ignores all write and read slots: no strobe, and read slots return 1s.
- R2: A line low time of more than 480 ticks is a guaranteed reset, and it works from any state. After the line rises, the block waits 30 ticks and then pulls the line low for 120 ticks (presence). After that it receives a fresh first byte.
- R3: During reception or acknowledge, a low time of more than 120 ticks that stays at or below 480 ticks abandons the transaction. No presence follows, and all slots are ignored until a guaranteed reset.
- R4: A write slot starts at a falling edge of the synchronized line. The bit is sampled 15 ticks later: low reads as 0 and high reads as 1. Bits fill the byte least significant bit first, so the code 0xCC is sent as bits 0,0,1,1,0,0,1,1.
- R5: The first byte after presence must be 0xCC (skip addressing). Any other value, including 0x33, makes the block ignore later slots until a guaranteed reset.
- R6: If the byte after 0xCC is 0x99, `cmd_strobe` is high for exactly one clock.
- R7: After 0x99 the block answers the next eight read slots with 0x55, least significant bit first. For a 0 bit it pulls the line for 30 ticks from the slot's falling edge. For a 1 bit it leaves the line released. Later read slots get 1s.
- R8: A byte other than 0x99 after 0xCC gives no strobe, and read slots return 1s until a guaranteed reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| line_in | input | 1 | Raw level of the shared data line |
| pull_low | output | 1 | Enable for the open-drain pull-down on the line |
| cmd_strobe | output | 1 | One-cycle pulse when the profile-programming command is decoded |

## Verification
The bench ticks every four clocks, and it places each sample far from any edge the design can move.

- **Presence (R2):** the pull-down starts about 30 ticks after the host releases the line plus a few synchronizer cycles, and ends about 150 ticks after release. The bench samples `pull_low` at 15, 90 and 200 ticks after release.
- **Read bits (R7):** each 0 bit is driven from three clocks after the host's falling edge until tick 30 of the slot. The bench samples the line at tick 12.
- **Command strobe (R6):** the strobe lasts one clock, so the bench counts it on every falling clock edge. It compares the count before and after each command.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_RST = 3'd0,
        ST_PP_WAIT  = 3'd1,
        ST_PP_DRIVE = 3'd2,
        ST_RX_SKIP  = 3'd3,
        ST_RX_CMD   = 3'd4,
        ST_TX_ACK   = 3'd5
    } sw_state_t;

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic fall,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              q_prev;

    // Idle level of an open-drain line is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= '1;
            q_prev <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], d};
            q_prev <= chain[STAGES-1];
        end
    end

    assign q    = chain[STAGES-1];
    assign fall = q_prev & ~q;
    assign rise = ~q_prev & q;

endmodule

// File: rtl/sw_lowtimer.sv
module sw_lowtimer #(
    parameter int T_MAY  = 120,
    parameter int T_MUST = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_s,
    output logic may_rst,
    output logic must_rst
);

    localparam int CW = $clog2(T_MUST + 2);

    logic [CW-1:0] cnt;

    // Counts ticks while the line stays low, saturating just past the upper threshold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (line_s) begin
            cnt <= '0;
        end else if (tick && cnt != CW'(T_MUST + 1)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign may_rst  = cnt > CW'(T_MAY);
    assign must_rst = cnt > CW'(T_MUST);

    AST_MUST_AFTER_MAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(must_rst) |-> $past(may_rst)); // R2

endmodule

// File: rtl/sw_shift.sv
module sw_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         full
);

    localparam int CNTW = $clog2(W + 1);

    logic [CNTW-1:0] bitcnt;

    // Least significant bit arrives first, so new bits enter at the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data   <= '0;
            bitcnt <= '0;
        end else if (clr) begin
            data   <= '0;
            bitcnt <= '0;
        end else if (shift_en) begin
            data   <= {bit_in, data[W-1:1]};
            bitcnt <= bitcnt + CNTW'(1);
        end
    end

    assign full = bitcnt == CNTW'(W);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> !full); // R4

endmodule

// File: rtl/sw_responder.sv
module sw_responder
    import sw_pkg::*;
#(
    parameter int               BYTE_W      = 8,
    parameter int               SYNC_STAGES = 2,
    parameter int               T_MAY       = 120,
    parameter int               T_MUST      = 480,
    parameter int               T_PP_WAIT   = 30,
    parameter int               T_PP_WIDTH  = 120,
    parameter int               T_SAMPLE    = 15,
    parameter int               T_RD_HOLD   = 30,
    parameter logic [BYTE_W-1:0] SKIP_CODE  = 8'hCC,
    parameter logic [BYTE_W-1:0] PROG_CODE  = 8'h99,
    parameter logic [BYTE_W-1:0] ACK_CODE   = 8'h55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_in,
    output logic pull_low,
    output logic cmd_strobe
);

    localparam int TMAX_A = (T_PP_WIDTH > T_PP_WAIT) ? T_PP_WIDTH : T_PP_WAIT;
    localparam int TMAX_B = (T_SAMPLE > T_RD_HOLD) ? T_SAMPLE : T_RD_HOLD;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW     = $clog2(TMAX + 2);
    localparam int IW     = $clog2(BYTE_W);

    sw_state_t          state, nstate;
    logic               line_s, line_fall, line_rise;
    logic               may_rst, must_rst;
    logic [BYTE_W-1:0]  rx_byte;
    logic               rx_full;
    logic [TW-1:0]      timer;
    logic               slot_on;
    logic [IW-1:0]      tx_idx;
    logic               bus_rst, in_rx, in_slot, leave;
    logic               sample_now, release_now, tx_last;

    sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s),
        .fall  (line_fall),
        .rise  (line_rise)
    );

    sw_lowtimer #(.T_MAY(T_MAY), .T_MUST(T_MUST)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .line_s   (line_s),
        .may_rst  (may_rst),
        .must_rst (must_rst)
    );

    sw_shift #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (leave),
        .shift_en (sample_now),
        .bit_in   (line_s),
        .data     (rx_byte),
        .full     (rx_full)
    );

    assign bus_rst     = line_rise & must_rst;
    assign in_rx       = (state == ST_RX_SKIP) || (state == ST_RX_CMD);
    assign in_slot     = in_rx || (state == ST_TX_ACK);
    assign leave       = (nstate != state) || bus_rst;
    assign sample_now  = slot_on && in_rx && (timer == TW'(T_SAMPLE));
    assign release_now = slot_on && (state == ST_TX_ACK) && (timer == TW'(T_RD_HOLD));
    assign tx_last     = tx_idx == IW'(BYTE_W - 1);

    // Next-state logic
    always_comb begin
        nstate = state;
        if (bus_rst) begin
            nstate = ST_PP_WAIT;
        end else begin
            unique case (state)
                ST_WAIT_RST: nstate = ST_WAIT_RST;
                ST_PP_WAIT: begin
                    if (us_tick && timer == TW'(T_PP_WAIT - 1)) nstate = ST_PP_DRIVE;
                end
                ST_PP_DRIVE: begin
                    if (us_tick && timer == TW'(T_PP_WIDTH - 1)) nstate = ST_RX_SKIP;
                end
                ST_RX_SKIP: begin
                    if (may_rst) nstate = ST_WAIT_RST;
                    else if (rx_full) nstate = (rx_byte == SKIP_CODE) ? ST_RX_CMD : ST_WAIT_RST;
                end
                ST_RX_CMD: begin
                    if (may_rst) nstate = ST_WAIT_RST;
                    else if (rx_full) nstate = (rx_byte == PROG_CODE) ? ST_TX_ACK : ST_WAIT_RST;
                end
                ST_TX_ACK: begin
                    if (may_rst) nstate = ST_WAIT_RST;
                    else if (release_now && tx_last) nstate = ST_WAIT_RST;
                end
                default: nstate = ST_WAIT_RST;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_RST;
        else        state <= nstate;
    end

    // Shared tick timer and slot tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer   <= '0;
            slot_on <= 1'b0;
        end else if (leave) begin
            timer   <= '0;
            slot_on <= 1'b0;
        end else if (line_fall && in_slot) begin
            timer   <= '0;
            slot_on <= 1'b1;
        end else begin
            if (us_tick && timer != TW'(TMAX + 1)) timer <= timer + TW'(1);
            if (sample_now || release_now) slot_on <= 1'b0;
        end
    end

    // Acknowledge bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           tx_idx <= '0;
        else if (leave)       tx_idx <= '0;
        else if (release_now) tx_idx <= tx_idx + IW'(1);
    end

    // Outputs
    always_comb begin
        pull_low   = 1'b0;
        cmd_strobe = 1'b0;
        unique case (state)
            ST_PP_DRIVE: pull_low   = 1'b1;
            ST_TX_ACK:   pull_low   = slot_on & ~ACK_CODE[tx_idx];
            ST_RX_CMD:   cmd_strobe = rx_full & ~may_rst & (rx_byte == PROG_CODE);
            default: ;
        endcase
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe); // R6

    AST_STROBE_INTO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> state == ST_TX_ACK); // R6

    AST_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
        (may_rst && !bus_rst && in_slot) |=> state == ST_WAIT_RST); // R3

    AST_PP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pull_low) && state == ST_PP_DRIVE) |-> $past(state) == ST_PP_WAIT); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RST && $past(state) == ST_WAIT_RST) |-> !pull_low && !cmd_strobe); // R1

endmodule

// File: tb/tb_sw_responder.sv
`timescale 1ns/1ps
module tb_sw_responder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic host_low = 1'b0;
    logic line_in;
    logic pull_low;
    logic cmd_strobe;
    int   checks = 0;
    int   failures = 0;
    int   n_strobe = 0;
    logic [1:0] div = '0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    // One tick every four clocks stands in for one microsecond
    always @(negedge clk) begin
        div     <= div + 2'd1;
        us_tick <= (div == 2'd3);
    end

    assign line_in = ~(host_low | pull_low);

    always @(negedge clk) if (rst_n && cmd_strobe) n_strobe++;

    sw_responder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .line_in    (line_in),
        .pull_low   (pull_low),
        .cmd_strobe (cmd_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic hold_low(input int n);
        host_low = 1'b1;
        wait_us(n);
        host_low = 1'b0;
    endtask

    task automatic write_bit(input bit b, input int strobe);
        host_low = 1'b1;
        wait_us(strobe);
        if (b) host_low = 1'b0;
        wait_us(30 - strobe);
        host_low = 1'b0;
        wait_us(4);
    endtask

    task automatic write_byte(input logic [7:0] v, input int strobe);
        for (int i = 0; i < 8; i++) write_bit(v[i], strobe);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            host_low = 1'b1;
            wait_us(1);
            host_low = 1'b0;
            wait_us(11);
            v[i] = line_in;
            wait_us(26);
        end
    endtask

    // Guaranteed reset, presence checked on the way (R2)
    task automatic bus_reset_presence(input string tag);
        hold_low(500);
        wait_us(15);
        chk(pull_low == 1'b0, {"R2 quiet before presence ", tag}, pull_low, 0);
        wait_us(75);
        chk(pull_low == 1'b1, {"R2 presence driven ", tag}, pull_low, 1);
        wait_us(110);
        chk(pull_low == 1'b0, {"R2 presence released ", tag}, pull_low, 0);
    endtask

    task automatic t_reset_state();
        logic [7:0] rd;
        int s0;
        chk(pull_low == 1'b0, "R1 pull_low after reset", pull_low, 0);
        chk(cmd_strobe == 1'b0, "R1 cmd_strobe after reset", cmd_strobe, 0);
        s0 = n_strobe;
        write_byte(8'hCC, 2);
        write_byte(8'h99, 2);
        read_byte(rd);
        chk(n_strobe == s0, "R1 no strobe before bus reset", n_strobe - s0, 0);
        chk(rd == 8'hFF, "R1 read ignored before bus reset", rd, 8'hFF);
    endtask

    task automatic t_program_ack();
        logic [7:0] rd;
        int s0;
        bus_reset_presence("main");
        s0 = n_strobe;
        write_byte(8'hCC, 10);
        write_byte(8'h99, 2);
        chk(n_strobe == s0 + 1, "R6 one strobe on 0x99", n_strobe - s0, 1);
        read_byte(rd);
        chk(rd == 8'h55, "R7 acknowledge byte", rd, 8'h55);
        read_byte(rd);
        chk(rd == 8'hFF, "R7 slots after acknowledge", rd, 8'hFF);
    endtask

    task automatic t_bad_skip();
        logic [7:0] rd;
        int s0;
        bus_reset_presence("order");
        s0 = n_strobe;
        write_byte(8'h33, 2);
        write_byte(8'h99, 2);
        read_byte(rd);
        chk(n_strobe == s0, "R4 reversed skip rejected", n_strobe - s0, 0);
        chk(rd == 8'hFF, "R4 no ack after reversed skip", rd, 8'hFF);
        bus_reset_presence("noskip");
        write_byte(8'h99, 2);
        write_byte(8'h99, 2);
        read_byte(rd);
        chk(n_strobe == s0, "R5 command without skip", n_strobe - s0, 0);
        chk(rd == 8'hFF, "R5 no ack without skip", rd, 8'hFF);
    endtask

    task automatic t_other_cmd();
        logic [7:0] rd;
        int s0;
        bus_reset_presence("other");
        s0 = n_strobe;
        write_byte(8'hCC, 2);
        write_byte(8'hF0, 2);
        read_byte(rd);
        chk(n_strobe == s0, "R8 no strobe on other code", n_strobe - s0, 0);
        chk(rd == 8'hFF, "R8 no ack on other code", rd, 8'hFF);
    endtask

    task automatic t_abandon();
        logic [7:0] rd;
        int s0;
        bus_reset_presence("abandon");
        s0 = n_strobe;
        write_byte(8'hCC, 2);
        hold_low(200);
        wait_us(90);
        chk(pull_low == 1'b0, "R3 no presence after mid low", pull_low, 0);
        write_byte(8'h99, 2);
        read_byte(rd);
        chk(n_strobe == s0, "R3 no strobe after abandon", n_strobe - s0, 0);
        chk(rd == 8'hFF, "R3 no ack after abandon", rd, 8'hFF);
    endtask

    task automatic t_reset_midway();
        logic [7:0] rd;
        int s0;
        bus_reset_presence("first");
        write_byte(8'hCC, 2);
        bus_reset_presence("restart");
        s0 = n_strobe;
        write_byte(8'hCC, 2);
        write_byte(8'h99, 2);
        read_byte(rd);
        chk(n_strobe == s0 + 1, "R2 strobe after restart", n_strobe - s0, 1);
        chk(rd == 8'h55, "R2 ack after restart", rd, 8'h55);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset_state();
        t_program_ack();
        t_bad_skip();
        t_other_cmd();
        t_abandon();
        t_reset_midway();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            report();
            $finish;
        end
    end

endmodule